// File: doc/BRIEF.md
# Versioned Masked-Write Register Bank with Frame-Aligned Commit

This block is the control register file of a display controller. Software writes 32-bit words at byte addresses. Each word holds one or more fields. A field is described by its byte offset, bit shift, bit mask, a flag that selects a masked-write word, and a window of hardware versions.

A field that is outside the window for the build's major/minor version is absent. Its bits cannot be written and always read as zero. Words that hold masked-write fields use their upper half-word as per-bit write enables for the lower half-word, so software can change one field without reading the word first. In the other words, every implemented bit simply takes the written data.

All writes land in a pending copy, and reads return that copy. Setting the commit bit arms a transfer. At the next frame-start pulse the pending copy moves into the active copy, which feeds the datapath and can be seen on a debug read port. The commit bit clears once the transfer is done.

The transfer is run by a three-state machine:
- IDLE: no commit outstanding.
- ARMED: a commit was requested and the block waits for frame start.
- COPY: the cycle in which pending is copied to active.

Transitions:
- IDLE→ARMED: a commit write.
- ARMED→COPY: a frame-start pulse.
- COPY→IDLE: no new commit write in that cycle.
- COPY→ARMED: another commit write in that cycle.

Top module: `rb_regbank`

## Requirements
- R1: After reset, every pending word, every active word and the commit bit read as zero.
- R2: In a plain word (words 1 and 2), a write sets every implemented bit to the written data bit. Bits that are not implemented stay zero.
- R3: In a masked-write word (words 0 and 3), a low bit n changes only when data bit n+16 is 1. The upper half-word is never stored.
- R4: Build version is major 2, minor 3. A field is present when its major is 0, or when its major is 2 and its minor window covers 3. The field map is listed below.
  - Word 0: bit 0 commit (major 0); bit 1 standby (major 0); bits 7:4 output select (major 2, minors 2–5); bits 9:8 legacy (major 1, absent).
  - Word 1: bits 11:0 line length (major 0); bits 23:16 sync width (major 2, minors 0–3).
  - Word 2: bits 23:0 background (major 2, minors 4–7, absent); bits 31:24 reserved.
  - Word 3: bits 2:0 polarity (major 2, minor 3 only); bits 15:8 extension (major 2, minors 0–2, absent).
  - Absent bits ignore writes and read zero.
- R5: A field with a zero mask (word 2, bits 31:24) is unimplemented. Writing it has no effect, and its bits read zero.
- R6: Addresses are byte addresses, and the word index is the address shifted right by 2. The two low address bits are ignored. A write at or beyond word 4 is dropped, and a read there returns zero.
- R7: Writing word 0 with bits 16 and 0 both set requests a commit. Reading word 0 bit 0 returns 1 while the commit is outstanding, and the active copy does not change.
- R8: The frame-start pulse is sampled while ARMED. At the next clock edge the active copy takes the pending values, including writes made while ARMED, and the commit bit clears.
- R9: A frame-start pulse with no commit outstanding leaves the active copy unchanged.
- R10: The read port returns pending values and the debug port returns active values. A write changes only the pending copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data word |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Pending word at rd_addr, with the commit bit merged in |
| frame_start | input | 1 | Frame-start pulse, one cycle |
| dbg_addr | input | 8 | Debug byte address |
| dbg_data | output | 32 | Active word at dbg_addr |

## Verification
The assertions assume that write strobes, addresses and frame-start pulses are stable across each rising edge. They also assume the block is not written before reset is released. The bench keeps within this: it changes every input on the falling edge, holds reset for several cycles before any access, and drives frame start as a single-cycle pulse. Commit writes are issued only as deliberate word-0 writes, because the sweep data always has bit 0 of word 0 cleared, so commit timing stays under the bench's control.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int DATA_W      = 32;
    localparam int HALF_W      = DATA_W / 2;
    localparam int NUM_FIELDS  = 10;
    localparam int COMMIT_FIELD = 0;
    localparam int COMMIT_WORD  = 0;
    localparam int COMMIT_BIT   = 0;

    typedef struct packed {
        logic [7:0]        offset;
        logic [4:0]        shift;
        logic [DATA_W-1:0] mask;
        logic              wmask;
        logic [2:0]        major;
        logic [3:0]        min_lo;
        logic [3:0]        min_hi;
    } field_t;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_ARMED = 2'd1,
        CM_COPY  = 2'd2
    } commit_state_e;

    function automatic field_t mk_field(input logic [7:0] off, input logic [4:0] sh,
                                        input logic [DATA_W-1:0] m, input logic wm,
                                        input logic [2:0] maj, input logic [3:0] lo,
                                        input logic [3:0] hi);
        field_t f;
        f.offset = off;
        f.shift  = sh;
        f.mask   = m;
        f.wmask  = wm;
        f.major  = maj;
        f.min_lo = lo;
        f.min_hi = hi;
        return f;
    endfunction

    // Field map of the bank; index COMMIT_FIELD is the commit request bit.
    function automatic field_t field_desc(input int idx);
        field_t f;
        case (idx)
            0:       f = mk_field(8'h00, 5'd0,  32'h1,      1'b1, 3'd0, 4'd0, 4'd0);
            1:       f = mk_field(8'h00, 5'd1,  32'h1,      1'b1, 3'd0, 4'd0, 4'd0);
            2:       f = mk_field(8'h00, 5'd4,  32'hF,      1'b1, 3'd2, 4'd2, 4'd5);
            3:       f = mk_field(8'h00, 5'd8,  32'h3,      1'b1, 3'd1, 4'd0, 4'd15);
            4:       f = mk_field(8'h04, 5'd0,  32'hFFF,    1'b0, 3'd0, 4'd0, 4'd0);
            5:       f = mk_field(8'h04, 5'd16, 32'hFF,     1'b0, 3'd2, 4'd0, 4'd3);
            6:       f = mk_field(8'h08, 5'd0,  32'hFFFFFF, 1'b0, 3'd2, 4'd4, 4'd7);
            7:       f = mk_field(8'h08, 5'd24, 32'h0,      1'b0, 3'd0, 4'd0, 4'd0);
            8:       f = mk_field(8'h0C, 5'd0,  32'h7,      1'b1, 3'd2, 4'd3, 4'd3);
            9:       f = mk_field(8'h0C, 5'd8,  32'hFF,     1'b1, 3'd2, 4'd0, 4'd2);
            default: f = mk_field(8'h00, 5'd0,  32'h0,      1'b0, 3'd0, 4'd0, 4'd0);
        endcase
        return f;
    endfunction

    function automatic logic field_present(input field_t f, input int hw_major, input int hw_minor);
        if (f.mask == '0)
            return 1'b0;
        if (f.major == 3'd0)
            return 1'b1;
        return (int'(f.major) == hw_major) &&
               (int'(f.min_lo) <= hw_minor) &&
               (int'(f.min_hi) >= hw_minor);
    endfunction

endpackage

// File: rtl/rb_field_map.sv
module rb_field_map
    import rb_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int HW_MAJOR  = 2,
    parameter int HW_MINOR  = 3
) (
    output logic [NUM_WORDS-1:0][DATA_W-1:0] writable,
    output logic [NUM_WORDS-1:0]             wm_word
);

    always_comb begin
        field_t f;
        writable = '0;
        wm_word  = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            f = field_desc(i);
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (int'(f.offset[7:2]) == w && f.mask != '0) begin
                    // Word kind is structural: absent fields still define it.
                    if (f.wmask)
                        wm_word[w] = 1'b1;
                    if (i != COMMIT_FIELD && field_present(f, HW_MAJOR, HW_MINOR))
                        writable[w] = writable[w] | (f.mask << f.shift);
                end
            end
        end
    end

endmodule

// File: rtl/rb_word.sv
module rb_word
    import rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] writable,
    input  logic              wm,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              copy_en,
    output logic [DATA_W-1:0] pend_q,
    output logic [DATA_W-1:0] act_q
);

    logic [DATA_W-1:0] upd_mask;
    logic [DATA_W-1:0] pend_d;

    always_comb begin
        if (wm)
            upd_mask = writable & {{HALF_W{1'b0}}, wr_data[DATA_W-1:HALF_W]};
        else
            upd_mask = writable;
        pend_d = (pend_q & ~upd_mask) | (wr_data & upd_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else if (wr_sel)
            pend_q <= pend_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            act_q <= '0;
        else if (copy_en)
            act_q <= pend_q;
    end

endmodule

// File: rtl/rb_commit_fsm.sv
module rb_commit_fsm
    import rb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit_req,
    input  logic frame_start,
    output logic copy_en,
    output logic busy
);

    commit_state_e state_q;
    commit_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CM_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_IDLE:  if (commit_req)  state_d = CM_ARMED;
            CM_ARMED: if (frame_start) state_d = CM_COPY;
            CM_COPY:  state_d = commit_req ? CM_ARMED : CM_IDLE;
            default:  state_d = CM_IDLE;
        endcase
    end

    always_comb begin
        copy_en = (state_q == CM_COPY);
        busy    = (state_q != CM_IDLE);
    end

endmodule

// File: rtl/rb_regbank.sv
module rb_regbank
    import rb_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 8,
    parameter int HW_MAJOR  = 2,
    parameter int HW_MINOR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [31:0]       dbg_data
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam int FLAT_W = NUM_WORDS * DATA_W;

    logic [NUM_WORDS-1:0][DATA_W-1:0] writable;
    logic [NUM_WORDS-1:0]             wm_word;
    logic [DATA_W-1:0]                pend_w [NUM_WORDS];
    logic [DATA_W-1:0]                act_w  [NUM_WORDS];
    logic [FLAT_W-1:0]                pend_flat;
    logic [FLAT_W-1:0]                act_flat;
    logic [FLAT_W-1:0]                writable_flat;

    logic [WIDX_W-1:0] wr_idx;
    logic [WIDX_W-1:0] rd_idx;
    logic [WIDX_W-1:0] dbg_idx;
    logic              wr_hit;
    logic              commit_req;
    logic              copy_en;
    logic              busy;

    assign wr_idx  = wr_addr[ADDR_W-1:2];
    assign rd_idx  = rd_addr[ADDR_W-1:2];
    assign dbg_idx = dbg_addr[ADDR_W-1:2];
    assign wr_hit  = wr_en && (32'(wr_idx) < NUM_WORDS);

    assign commit_req = wr_hit && (wr_idx == WIDX_W'(COMMIT_WORD)) &&
                        wr_data[COMMIT_BIT + HALF_W] && wr_data[COMMIT_BIT];

    rb_field_map #(
        .NUM_WORDS (NUM_WORDS),
        .HW_MAJOR  (HW_MAJOR),
        .HW_MINOR  (HW_MINOR)
    ) u_map (
        .writable (writable),
        .wm_word  (wm_word)
    );

    rb_commit_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_req  (commit_req),
        .frame_start (frame_start),
        .copy_en     (copy_en),
        .busy        (busy)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        rb_word u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .writable (writable[w]),
            .wm       (wm_word[w]),
            .wr_sel   (wr_hit && (wr_idx == WIDX_W'(w))),
            .wr_data  (wr_data),
            .copy_en  (copy_en),
            .pend_q   (pend_w[w]),
            .act_q    (act_w[w])
        );
        assign pend_flat[w*DATA_W +: DATA_W] = pend_w[w];
        assign act_flat[w*DATA_W +: DATA_W]  = act_w[w];
    end

    assign writable_flat = writable;

    always_comb begin
        rd_data  = '0;
        dbg_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_idx == WIDX_W'(w)) begin
                rd_data = pend_w[w];
                if (w == COMMIT_WORD)
                    rd_data[COMMIT_BIT] = busy;
            end
            if (dbg_idx == WIDX_W'(w))
                dbg_data = act_w[w];
        end
    end

endmodule

// File: rtl/rb_regbank_checker.sv
module rb_regbank_checker #(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [31:0]             wr_data,
    input logic                    copy_en,
    input logic                    busy,
    input logic [NUM_WORDS*32-1:0] pend_flat,
    input logic [NUM_WORDS*32-1:0] act_flat,
    input logic [NUM_WORDS*32-1:0] writable_flat
);

    // R4 / R5: absent or unimplemented bits never hold a one.
    assert_absent_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flat & ~writable_flat) == '0);

    // R6: a write beyond the last word leaves the pending copy alone.
    assert_out_of_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_addr >> 2) >= NUM_WORDS)) |=> $stable(pend_flat));

    // R7: commit goes outstanding only after a word-0 write with bits 16 and 0.
    assert_commit_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && (wr_addr >> 2) == '0 && wr_data[16] && wr_data[0]));

    // R8: the copy moves the pending values into the active copy.
    assert_copy_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> (act_flat == $past(pend_flat)));

    // R8: the commit bit clears only through a copy.
    assert_commit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(copy_en));

    // R9: without an outstanding commit no copy follows.
    assert_idle_no_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !copy_en);

    // R10: the active copy changes only in a copy cycle.
    assert_active_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_en |=> $stable(act_flat));

endmodule

bind rb_regbank rb_regbank_checker #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .copy_en       (copy_en),
    .busy          (busy),
    .pend_flat     (pend_flat),
    .act_flat      (act_flat),
    .writable_flat (writable_flat)
);

// File: tb/rb_regbank_test.sv
module rb_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        frame_start = 1'b0;
    logic [7:0]  dbg_addr = '0;
    logic [31:0] dbg_data;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pend [4];
    logic [31:0] m_act  [4];
    logic        m_busy;

    always #5 clk = ~clk;

    rb_regbank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .frame_start (frame_start),
        .dbg_addr    (dbg_addr),
        .dbg_data    (dbg_data)
    );

    // Version window rule for build 2.3.
    function automatic logic present(input int maj, input int lo, input int hi);
        return (maj == 0) || (maj == 2 && lo <= 3 && hi >= 3);
    endfunction

    function automatic logic [31:0] exp_mask(input int w);
        case (w)
            0: return (present(0, 0, 0) ? 32'h2 : 32'h0) |
                      (present(2, 2, 5) ? 32'hF0 : 32'h0) |
                      (present(1, 0, 15) ? 32'h300 : 32'h0);
            1: return (present(0, 0, 0) ? 32'hFFF : 32'h0) |
                      (present(2, 0, 3) ? 32'h00FF_0000 : 32'h0);
            2: return (present(2, 4, 7) ? 32'h00FF_FFFF : 32'h0);
            3: return (present(2, 3, 3) ? 32'h7 : 32'h0) |
                      (present(2, 0, 2) ? 32'hFF00 : 32'h0);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic is_wm(input int w);
        return (w == 0) || (w == 3);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] addr, input logic [31:0] d);
        int w;
        logic [31:0] upd;
        w = int'(addr >> 2);
        if (w < 4) begin
            upd = exp_mask(w);
            if (is_wm(w))
                upd = upd & {16'h0, d[31:16]};
            m_pend[w] = (m_pend[w] & ~upd) | (d & upd);
            if (w == 0 && d[16] && d[0])
                m_busy = 1'b1;
        end
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        model_write(addr, d);
    endtask

    task automatic check_word(input string tag, input int w);
        logic [31:0] exp;
        rd_addr  = 8'(w * 4);
        dbg_addr = 8'(w * 4);
        #1;
        exp = (w < 4) ? m_pend[w] : 32'h0;
        if (w == 0)
            exp[0] = m_busy;
        check({tag, " read"}, rd_data, exp);
        check({tag, " debug"}, dbg_data, (w < 4) ? m_act[w] : 32'h0);
    endtask

    task automatic check_all(input string tag);
        for (int w = 0; w < 4; w++)
            check_word(tag, w);
    endtask

    // Drives one frame-start pulse and checks the copy a cycle later.
    task automatic frame_pulse(input string tag);
        logic was_busy;
        was_busy = m_busy;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (was_busy) begin
            rd_addr = 8'h00;
            #1;
            check({tag, " busy during copy"}, 32'(rd_data[0]), 32'h1);
        end
        @(negedge clk);
        if (was_busy) begin
            for (int w = 0; w < 4; w++)
                m_act[w] = m_pend[w];
            m_busy = 1'b0;
        end
        check_all(tag);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < 4; w++) begin
            m_pend[w] = '0;
            m_act[w]  = '0;
        end
        m_busy = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1 reset");

        // Sweep over every word: R2 plain, R3 masked-write, R4/R5 gating, R10 active untouched
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 16; p++) begin
                logic [31:0] d;
                d = (32'h9E37_79B9 * 32'(p + 1)) ^ (32'(w) << 8) ^ 32'(p << 20);
                if (w == 0)
                    d[0] = 1'b0;
                do_write(8'(w * 4), d);
                case (w)
                    0: check_word("R3 word0 sweep", w);
                    1: check_word("R2 word1 sweep", w);
                    2: check_word("R5 word2 sweep R4", w);
                    default: check_word("R3 word3 sweep R4", w);
                endcase
            end
        end

        // R2: all ones then all zeros in a plain word
        do_write(8'h04, 32'hFFFF_FFFF);
        check_word("R2 all ones", 1);
        do_write(8'h04, 32'h0000_0000);
        check_word("R2 all zeros", 1);

        // R3: no enables -> no change; then enabled update; upper half not stored
        do_write(8'h0C, 32'h0007_0005);
        check_word("R3 enabled set", 3);
        do_write(8'h0C, 32'h0000_FFFF);
        check_word("R3 no enables", 3);
        do_write(8'h0C, 32'h0002_0000);
        check_word("R3 single enable clear", 3);
        do_write(8'h00, 32'hFFFE_FFFE);
        check_word("R3 word0 full enable", 0);

        // R4: absent fields in word 0 (bits 9:8) and word 3 (bits 15:8)
        do_write(8'h00, 32'h0300_0300);
        check_word("R4 absent legacy", 0);
        do_write(8'h0C, 32'hFF00_FF00);
        check_word("R4 absent extension", 3);

        // R6: unaligned address maps to the word, out of range dropped
        do_write(8'h05, 32'h0000_0ABC);
        check_word("R6 unaligned", 1);
        do_write(8'h10, 32'hFFFF_FFFF);
        do_write(8'hFC, 32'hFFFF_FFFF);
        check_word("R6 beyond last", 4);
        rd_addr = 8'hFC;
        #1;
        check("R6 top address read", rd_data, 32'h0);
        check_all("R6 others unchanged");

        // R9: frame start with nothing outstanding
        frame_pulse("R9 idle frame");

        // R7: request commit, active stays put
        do_write(8'h00, 32'h0001_0001);
        check_all("R7 armed");
        repeat (3) @(negedge clk);
        check_all("R7 still armed");

        // R8: write while armed is included in the copy
        do_write(8'h04, 32'h0055_0123);
        do_write(8'h0C, 32'h0007_0006);
        frame_pulse("R8 commit copy");

        // R10: later writes reach pending only
        do_write(8'h04, 32'h0011_0FED);
        do_write(8'h00, 32'h00F2_0000);
        check_all("R10 pending only");

        // R9 again after a completed commit
        frame_pulse("R9 second idle frame");

        // R8: second commit round
        do_write(8'h00, 32'h0001_0001);
        frame_pulse("R8 second copy");

        finish_run();
    end

endmodule